// File: doc/BRIEF.md
# ECC Memory Error Status and Capture Unit

This unit sits beside an ECC-protected memory controller and records what went wrong. The controller pulses single-bit (correctable) and multi-bit (uncorrectable) error inputs, plus a few other error kinds. For the ECC kinds it also presents the failing data halves, the check bits and the address. Software reads pending errors from a status word, clears them by writing ones and chooses which kinds raise the interrupt line.

Correctable errors pass through an 8-bit programmable threshold counter before they are reported. This lets a noisy but harmless memory be throttled. The first reported ECC error freezes the capture registers. Any later ECC error before software clears the status only raises an overflow flag, so the captured context always belongs to the oldest unhandled event. Three error-injection words are held as plain read/write storage for the datapath to use.

Top module: `memerr_capture_unit`

## Requirements
- R1: After reset the status word reads 0, the type-mask word reads all type bits set (0x1F with three other kinds), the interrupt-enable word reads 0, the threshold/count word reads 0x00010000 (threshold 1, count 0), the capture and injection words read 0 and `irq` is low.
- R2: Status word (index 0): bit 0 is correctable, bit 1 is uncorrectable, bits 2 and up are the other kinds and bit 31 is the overflow flag. Writing a 1 to a bit clears it and writing a 0 leaves it alone. An event that sets a bit in the same cycle as a clear of that bit wins.
- R3: Type-mask word (index 1) uses the same bit positions as the status word for the error kinds. While a kind's bit is 1, events of that kind neither set status nor advance the counter. Writing 0 enables every kind.
- R4: Interrupt-enable word (index 2) uses the same kind positions. `irq` is high exactly when some status kind bit and its enable bit are both 1. It follows status one cycle after an event or clear.
- R5: Threshold/count word (index 3) holds the threshold in bits 23:16 and reads the running count in bits 7:0. Each unmasked correctable event increments the count. The event that brings it to the threshold sets status bit 0 and returns the count to 0. Any write to this word clears the count and discards a correctable event in that cycle.
- R6: A threshold of 0 disables correctable reporting: status bit 0 never sets and the count stays 0.
- R7: An unmasked uncorrectable event sets status bit 1 on the next clock edge, with no counting.
- R8: Capture words (index 4 data high, 5 data low, 6 check bits, 7 address) load from the capture inputs when a reported ECC event arrives while status bits 0 and 1 are both clear. Writes to them are ignored.
- R9: A reported ECC event while status bit 0 or 1 is set sets the overflow flag and leaves the capture words unchanged. Capture reopens once both bits are cleared.
- R10: Other-kind events set their status bits (2 and up) but never load the capture words or set the overflow flag.
- R11: Injection words (index 8 data high, 9 data low, 10 control) read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at `bus_addr`, combinational |
| ev_sbe | input | 1 | Correctable (single-bit) error pulse |
| ev_mbe | input | 1 | Uncorrectable (multi-bit) error pulse |
| ev_other | input | OTHER_N | Other error kind pulses |
| cap_hi_in | input | HALF_W | Failing data high half |
| cap_lo_in | input | HALF_W | Failing data low half |
| cap_ecc_in | input | ECC_W | Failing check bits / syndrome |
| cap_addr_in | input | ADDR_W | Failing address |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that event inputs are single-cycle samples of the controller's detection and that the capture inputs are valid whenever an ECC event is high. They also assume that only one register write happens per cycle. The bench therefore drives events, capture values and at most one write together on the falling edge. Randomly chosen register indices stay inside the eleven defined words, and threshold values stay small so that counting wraps and reports often. Every random cycle is compared against a reference model of the status, count and capture rules.

// File: rtl/memerr_pkg.sv
package memerr_pkg;
   localparam int BUS_W     = 32;
   localparam int BIT_SBE   = 0;
   localparam int BIT_MBE   = 1;
   localparam int BIT_OVF   = 31;
   localparam int THR_LSB   = 16;

   typedef enum logic [3:0] {
      RA_STATUS  = 4'd0,
      RA_MASK    = 4'd1,
      RA_IEN     = 4'd2,
      RA_THRESH  = 4'd3,
      RA_CAP_HI  = 4'd4,
      RA_CAP_LO  = 4'd5,
      RA_CAP_ECC = 4'd6,
      RA_CAP_ADR = 4'd7,
      RA_INJ_HI  = 4'd8,
      RA_INJ_LO  = 4'd9,
      RA_INJ_CTL = 4'd10
   } reg_idx_e;
endpackage

// File: rtl/memerr_sbe_filter.sv
module memerr_sbe_filter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sbe_hit,
   input  logic [CNT_W-1:0] thresh,
   input  logic             cnt_clr,
   output logic             report,
   output logic [CNT_W-1:0] count
);
   localparam int EXT_W = CNT_W + 1;

   logic [EXT_W-1:0] next_cnt;
   logic             armed;

   assign next_cnt = {1'b0, count} + EXT_W'(1);
   assign armed    = sbe_hit && (thresh != '0) && !cnt_clr;
   assign report   = armed && (next_cnt == {1'b0, thresh});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (cnt_clr) begin
         count <= '0;
      end else if (armed) begin
         if (report) count <= '0;
         else        count <= next_cnt[CNT_W-1:0];
      end
   end

   // R5: the running count never reaches a nonzero threshold
   p_cnt_below_thr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (thresh != '0) |-> (count < thresh));

   // R6: with a zero threshold the count stays parked at zero
   p_zero_thr_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (thresh == '0) |=> (count == '0));
endmodule

// File: rtl/memerr_capture.sv
module memerr_capture #(
   parameter int HALF_W = 32,
   parameter int ECC_W  = 8,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ecc_evt,
   input  logic              locked,
   input  logic [HALF_W-1:0] din_hi,
   input  logic [HALF_W-1:0] din_lo,
   input  logic [ECC_W-1:0]  din_ecc,
   input  logic [ADDR_W-1:0] din_addr,
   output logic [HALF_W-1:0] cap_hi,
   output logic [HALF_W-1:0] cap_lo,
   output logic [ECC_W-1:0]  cap_ecc,
   output logic [ADDR_W-1:0] cap_addr
);
   logic load;
   assign load = ecc_evt && !locked;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_hi   <= '0;
         cap_lo   <= '0;
         cap_ecc  <= '0;
         cap_addr <= '0;
      end else if (load) begin
         cap_hi   <= din_hi;
         cap_lo   <= din_lo;
         cap_ecc  <= din_ecc;
         cap_addr <= din_addr;
      end
   end

   // R9: a held capture is not overwritten
   p_capture_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> ($stable(cap_hi) && $stable(cap_lo) && $stable(cap_ecc) && $stable(cap_addr)));

   // R8: the first reported ECC event is recorded
   p_capture_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ecc_evt && !locked) |=> (cap_addr == $past(din_addr) && cap_ecc == $past(din_ecc)));
endmodule

// File: rtl/memerr_capture_unit.sv
module memerr_capture_unit
   import memerr_pkg::*;
#(
   parameter int HALF_W  = 32,
   parameter int ECC_W   = 8,
   parameter int ADDR_W  = 32,
   parameter int OTHER_N = 3,
   parameter int CNT_W   = 8,
   parameter bit INJ_EN  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wen,
   input  logic [3:0]         bus_addr,
   input  logic [BUS_W-1:0]   bus_wdata,
   output logic [BUS_W-1:0]   bus_rdata,
   input  logic               ev_sbe,
   input  logic               ev_mbe,
   input  logic [OTHER_N-1:0] ev_other,
   input  logic [HALF_W-1:0]  cap_hi_in,
   input  logic [HALF_W-1:0]  cap_lo_in,
   input  logic [ECC_W-1:0]   cap_ecc_in,
   input  logic [ADDR_W-1:0]  cap_addr_in,
   output logic               irq
);
   localparam int TYPE_N = 2 + OTHER_N;

   if (HALF_W < 1 || HALF_W > BUS_W) begin : g_chk_half
      $error("HALF_W must be 1..32");
   end
   if (ECC_W < 1 || ECC_W > BUS_W) begin : g_chk_ecc
      $error("ECC_W must be 1..32");
   end
   if (ADDR_W < 1 || ADDR_W > BUS_W) begin : g_chk_addr
      $error("ADDR_W must be 1..32");
   end
   if (OTHER_N < 1 || OTHER_N > 28) begin : g_chk_other
      $error("OTHER_N must be 1..28");
   end
   if (CNT_W < 1 || CNT_W > 8) begin : g_chk_cnt
      $error("CNT_W must be 1..8");
   end

   logic [TYPE_N-1:0] status_q, mask_q, ien_q;
   logic              ovf_q;
   logic [CNT_W-1:0]  thresh_q, count;
   logic [HALF_W-1:0] cap_hi, cap_lo;
   logic [ECC_W-1:0]  cap_ecc;
   logic [ADDR_W-1:0] cap_addr;
   logic [BUS_W-1:0]  inj_hi, inj_lo, inj_ctl;

   logic wr_status, wr_mask, wr_ien, wr_thresh;
   logic sbe_hit, mbe_hit, sbe_report, ecc_evt, ecc_locked;
   logic [OTHER_N-1:0] other_hit;
   logic [TYPE_N-1:0]  set_vec, clr_vec;

   assign wr_status = bus_wen && (bus_addr == RA_STATUS);
   assign wr_mask   = bus_wen && (bus_addr == RA_MASK);
   assign wr_ien    = bus_wen && (bus_addr == RA_IEN);
   assign wr_thresh = bus_wen && (bus_addr == RA_THRESH);

   assign sbe_hit    = ev_sbe && !mask_q[BIT_SBE];
   assign mbe_hit    = ev_mbe && !mask_q[BIT_MBE];
   assign other_hit  = ev_other & ~mask_q[TYPE_N-1:2];
   assign ecc_evt    = sbe_report || mbe_hit;
   assign ecc_locked = status_q[BIT_SBE] || status_q[BIT_MBE];
   assign set_vec    = {other_hit, mbe_hit, sbe_report};
   assign clr_vec    = wr_status ? bus_wdata[TYPE_N-1:0] : '0;

   memerr_sbe_filter #(.CNT_W(CNT_W)) u_filter (
      .clk     (clk),
      .rst_n   (rst_n),
      .sbe_hit (sbe_hit),
      .thresh  (thresh_q),
      .cnt_clr (wr_thresh),
      .report  (sbe_report),
      .count   (count)
   );

   memerr_capture #(.HALF_W(HALF_W), .ECC_W(ECC_W), .ADDR_W(ADDR_W)) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .ecc_evt  (ecc_evt),
      .locked   (ecc_locked),
      .din_hi   (cap_hi_in),
      .din_lo   (cap_lo_in),
      .din_ecc  (cap_ecc_in),
      .din_addr (cap_addr_in),
      .cap_hi   (cap_hi),
      .cap_lo   (cap_lo),
      .cap_ecc  (cap_ecc),
      .cap_addr (cap_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
         ovf_q    <= 1'b0;
         mask_q   <= '1;
         ien_q    <= '0;
         thresh_q <= CNT_W'(1);
      end else begin
         status_q <= (status_q & ~clr_vec) | set_vec;
         ovf_q    <= (ovf_q & !(wr_status && bus_wdata[BIT_OVF])) | (ecc_evt && ecc_locked);
         if (wr_mask)   mask_q   <= bus_wdata[TYPE_N-1:0];
         if (wr_ien)    ien_q    <= bus_wdata[TYPE_N-1:0];
         if (wr_thresh) thresh_q <= bus_wdata[THR_LSB +: CNT_W];
      end
   end

   if (INJ_EN) begin : g_inj
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            inj_hi  <= '0;
            inj_lo  <= '0;
            inj_ctl <= '0;
         end else if (bus_wen) begin
            if (bus_addr == RA_INJ_HI)  inj_hi  <= bus_wdata;
            if (bus_addr == RA_INJ_LO)  inj_lo  <= bus_wdata;
            if (bus_addr == RA_INJ_CTL) inj_ctl <= bus_wdata;
         end
      end
   end else begin : g_no_inj
      assign inj_hi  = '0;
      assign inj_lo  = '0;
      assign inj_ctl = '0;
   end

   assign irq = |(status_q & ien_q);

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         RA_STATUS: begin
            bus_rdata[TYPE_N-1:0] = status_q;
            bus_rdata[BIT_OVF]    = ovf_q;
         end
         RA_MASK:    bus_rdata[TYPE_N-1:0] = mask_q;
         RA_IEN:     bus_rdata[TYPE_N-1:0] = ien_q;
         RA_THRESH: begin
            bus_rdata[THR_LSB +: CNT_W] = thresh_q;
            bus_rdata[CNT_W-1:0]        = count;
         end
         RA_CAP_HI:  bus_rdata[HALF_W-1:0] = cap_hi;
         RA_CAP_LO:  bus_rdata[HALF_W-1:0] = cap_lo;
         RA_CAP_ECC: bus_rdata[ECC_W-1:0]  = cap_ecc;
         RA_CAP_ADR: bus_rdata[ADDR_W-1:0] = cap_addr;
         RA_INJ_HI:  bus_rdata = inj_hi;
         RA_INJ_LO:  bus_rdata = inj_lo;
         RA_INJ_CTL: bus_rdata = inj_ctl;
         default:    bus_rdata = '0;
      endcase
   end

   // R7: an unmasked uncorrectable event always lands in status
   p_mbe_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mbe_hit |=> status_q[BIT_MBE]);

   // R2: write-one clears a bit when no event re-sets it
   p_w1c_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_status && bus_wdata[BIT_MBE] && !mbe_hit) |=> !status_q[BIT_MBE]);

   // R3: a masked uncorrectable event leaves a clear status bit clear
   p_masked_mbe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_mbe && mask_q[BIT_MBE] && !status_q[BIT_MBE] && !wr_status) |=> !status_q[BIT_MBE]);

   // R6: zero threshold never reports a correctable error
   p_zero_thr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (thresh_q == '0 && !status_q[BIT_SBE]) |=> !status_q[BIT_SBE]);

   // R9: a second ECC report while locked raises overflow
   p_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ecc_evt && ecc_locked) |=> ovf_q);
endmodule

// File: tb/memerr_capture_unit_test.sv
module memerr_capture_unit_test;
   localparam int ON = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wen = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        ev_sbe = 1'b0, ev_mbe = 1'b0;
   logic [ON-1:0] ev_other = '0;
   logic [31:0] cap_hi_in = '0, cap_lo_in = '0, cap_addr_in = '0;
   logic [7:0]  cap_ecc_in = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;

   logic [4:0]  m_st, m_mask, m_ien;
   logic        m_ovf;
   logic [7:0]  m_thr, m_cnt, m_cecc;
   logic [31:0] m_chi, m_clo, m_cadr, m_ihi, m_ilo, m_ictl;

   memerr_capture_unit uut (
      .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_sbe(ev_sbe),
      .ev_mbe(ev_mbe), .ev_other(ev_other), .cap_hi_in(cap_hi_in),
      .cap_lo_in(cap_lo_in), .cap_ecc_in(cap_ecc_in), .cap_addr_in(cap_addr_in),
      .irq(irq)
   );

   always #5 clk = ~clk;

   function automatic logic [31:0] exp_read(input int a);
      case (a)
         0:  return {m_ovf, 26'd0, m_st};
         1:  return {27'd0, m_mask};
         2:  return {27'd0, m_ien};
         3:  return {8'd0, m_thr, 8'd0, m_cnt};
         4:  return m_chi;
         5:  return m_clo;
         6:  return {24'd0, m_cecc};
         7:  return m_cadr;
         8:  return m_ihi;
         9:  return m_ilo;
         10: return m_ictl;
         default: return 32'd0;
      endcase
   endfunction

   function automatic string tag_of(input int a);
      case (a)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3: return "R5";
         4, 5, 6, 7: return "R8";
         default: return "R11";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic model_reset();
      m_st = '0; m_mask = 5'h1F; m_ien = '0; m_ovf = 1'b0;
      m_thr = 8'd1; m_cnt = '0; m_cecc = '0;
      m_chi = '0; m_clo = '0; m_cadr = '0; m_ihi = '0; m_ilo = '0; m_ictl = '0;
   endtask

   task automatic check_all(input string why);
      for (int a = 0; a <= 10; a++) begin
         bus_addr = 4'(a);
         #1;
         chk($sformatf("%s %s idx%0d", tag_of(a), why, a), bus_rdata, exp_read(a));
      end
      chk($sformatf("R4 %s irq", why), {31'd0, irq}, {31'd0, |(m_st & m_ien)});
   endtask

   // one clock of stimulus, model advanced from the requirements
   task automatic step(input bit sbe, input bit mbe, input logic [ON-1:0] oth,
                       input bit wen, input logic [3:0] a, input logic [31:0] wd,
                       input string why);
      logic sbe_hit, mbe_hit, rep, evt, locked;
      logic [ON-1:0] oh;
      logic [4:0] clr;
      ev_sbe = sbe; ev_mbe = mbe; ev_other = oth;
      bus_wen = wen; bus_addr = a; bus_wdata = wd;
      cap_hi_in = $urandom; cap_lo_in = $urandom; cap_addr_in = $urandom;
      cap_ecc_in = 8'($urandom);
      sbe_hit = sbe && !m_mask[0];
      mbe_hit = mbe && !m_mask[1];
      oh = oth & ~m_mask[4:2];
      rep = 1'b0;
      if (wen && a == 4'd3) m_cnt = 8'd0;
      else if (sbe_hit && m_thr != 0) begin
         if (m_cnt + 8'd1 == m_thr) begin rep = 1'b1; m_cnt = 8'd0; end
         else m_cnt = m_cnt + 8'd1;
      end
      evt = rep || mbe_hit;
      locked = m_st[0] || m_st[1];
      if (evt && !locked) begin
         m_chi = cap_hi_in; m_clo = cap_lo_in; m_cadr = cap_addr_in; m_cecc = cap_ecc_in;
      end
      clr = (wen && a == 4'd0) ? wd[4:0] : 5'd0;
      m_ovf = (m_ovf && !(wen && a == 4'd0 && wd[31])) || (evt && locked);
      m_st = (m_st & ~clr) | {oh, mbe_hit, rep};
      if (wen) begin
         case (a)
            4'd1:  m_mask = wd[4:0];
            4'd2:  m_ien = wd[4:0];
            4'd3:  m_thr = wd[23:16];
            4'd8:  m_ihi = wd;
            4'd9:  m_ilo = wd;
            4'd10: m_ictl = wd;
            default: ;
         endcase
      end
      @(posedge clk);
      @(negedge clk);
      ev_sbe = 1'b0; ev_mbe = 1'b0; ev_other = '0; bus_wen = 1'b0;
      check_all(why);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] wd, input string why);
      step(0, 0, '0, 1, a, wd, why);
   endtask

   initial begin
      logic [31:0] hold_addr;
      void'($urandom(32'h5EED1234));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 reset");

      wr(4'd1, 32'h0, "R3 unmask all");
      wr(4'd2, 32'h3, "R4 enable ecc irq");
      step(0, 1, '0, 0, 0, 0, "R7 R8 first mbe");
      chk("R4 irq after mbe", {31'd0, irq}, 32'd1);
      hold_addr = m_cadr;
      step(0, 1, '0, 0, 0, 0, "R9 second mbe");
      chk("R9 overflow set", {31'd0, exp_read(0)[31]}, 32'd1);
      bus_addr = 4'd7; #1;
      chk("R9 capture held", bus_rdata, hold_addr);
      wr(4'd0, 32'h8000_0002, "R2 w1c clear");
      chk("R4 irq released", {31'd0, irq}, 32'd0);

      wr(4'd3, 32'h0003_0000, "R5 threshold 3");
      step(1, 0, '0, 0, 0, 0, "R5 sbe one");
      step(1, 0, '0, 0, 0, 0, "R5 sbe two");
      bus_addr = 4'd3; #1;
      chk("R5 count two", bus_rdata, 32'h0003_0002);
      step(1, 0, '0, 0, 0, 0, "R5 sbe three reports");
      chk("R5 sbe status", {31'd0, exp_read(0)[0]}, 32'd1);
      wr(4'd0, 32'h1, "R2 clear sbe");

      wr(4'd3, 32'h0, "R6 threshold zero");
      for (int i = 0; i < 5; i++) step(1, 0, '0, 0, 0, 0, "R6 sbe ignored");

      wr(4'd1, 32'h2, "R3 mask mbe");
      step(0, 1, '0, 0, 0, 0, "R3 masked mbe");
      wr(4'd1, 32'h0, "R3 unmask");

      step(0, 0, 3'b101, 0, 0, 0, "R10 other kinds");
      step(0, 1, '0, 1, 4'd0, 32'h2, "R2 set beats clear");
      wr(4'd0, 32'h8000_001F, "R2 clear all");

      wr(4'd8, 32'hDEAD_BEEF, "R11 inj hi");
      wr(4'd9, 32'h0123_4567, "R11 inj lo");
      wr(4'd10, 32'h0000_00A5, "R11 inj ctl");
      wr(4'd5, 32'hFFFF_FFFF, "R8 capture write ignored");

      for (int n = 0; n < 3000; n++) begin
         bit w;
         logic [3:0] a;
         logic [31:0] d;
         w = ($urandom_range(0, 5) == 0);
         a = 4'($urandom_range(0, 10));
         d = $urandom;
         if (a == 4'd3) d = {8'd0, 8'($urandom_range(0, 4)), 16'd0};
         if (a == 4'd1) d = {27'd0, 5'($urandom_range(0, 31) & ($urandom_range(0, 1) ? 5'h00 : 5'h1F))};
         step($urandom_range(0, 2) == 0, $urandom_range(0, 9) == 0,
              ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'd0,
              w, a, d, "random");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule